// File: doc/BRIEF.md
# 8-bit host to 16-bit IDE register bridge

This block sits between a narrow 8-bit host I/O port and the 16-bit register interface of an IDE/ATA drive. The host presents a 4-bit offset, a byte of write data and single-cycle read or write strobes. The drive side has two chip selects (command block and control block), a 3-bit register address, a 16-bit data bus in each direction, and read and write strobes. Each host offset is decoded into a drive register, into one of two high-byte latches, or into nothing.

Full 16-bit data words cross the 8-bit port in two steps. When the host reads the data register, it receives the low byte, and the bridge keeps the high byte in an inbound latch. The host then reads that byte from a separate offset. For a write, the host first places the high byte in an outbound latch at that separate offset. A following write of the low byte to the data register then sends both halves to the drive in a single 16-bit write. A build-time parameter chooses between the default offset map and an alternate map that moves the registers to other offsets.

Each host access starts the drive access on the next clock. Read data reaches the host one clock after the drive strobe. The host may start at most one access per clock. If both host strobes are high together, the read is taken and the write is dropped.

Top module: `byte_ide_bridge`

## Requirements
- R1: A host read at the data offset starts one drive read with the command chip select at register 0. The host receives drive bits 7:0, and the inbound latch captures drive bits 15:8 in the same access.
- R2: A host read at the high-byte offset (8 in the default map, 1 in the alternate map) returns the inbound latch and makes no drive access.
- R3: A host write at the high-byte offset loads the outbound latch and makes no drive access.
- R4: A host write at the data offset makes one drive write to command register 0. Its drive data is {outbound latch, host byte}.
- R5: In the default map, offsets 1 to 7 access command registers 1 to 7. A write to any of them drives {8'h00, host byte}.
- R6: In the default map, offset 14 accesses register 6 with the control chip select, for both reads and writes.
- R7: With ALT_MAP=1, the offsets map as follows: data at 0, high byte at 1, sector count at 2, cylinder low at 4, drive/head at 6, control register 6 at 7, command register 1 at 8, sector number at 10, cylinder high at 12, status/command at 14.
- R8: Any offset not assigned in the active map returns 8'h00 on a read. A write to it is ignored: there is no drive access and neither latch changes.
- R9: After reset, both latches and the host read data are 8'h00, and no drive strobe is active.
- R10: Each latch keeps its value until it is loaded again. Reads of other registers leave the inbound latch unchanged. Repeated data writes reuse the same outbound byte.
- R11: A host access that reaches the drive asserts exactly one chip select and one strobe, for exactly the clock after the host strobe. Read data appears on the host port one clock later and holds until the next read. With no drive access, the chip selects, address and write data are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_ofs | input | 4 | Host register offset |
| host_rd | input | 1 | Host read strobe, one cycle per access |
| host_wr | input | 1 | Host write strobe, one cycle per access |
| host_wdata | input | 8 | Host write byte |
| host_rdata | output | 8 | Host read byte, held until the next read |
| dev_cs_cmd | output | 1 | Drive command-block chip select |
| dev_cs_ctl | output | 1 | Drive control-block chip select |
| dev_addr | output | 3 | Drive register address |
| dev_rd | output | 1 | Drive read strobe |
| dev_wr | output | 1 | Drive write strobe |
| dev_wdata | output | 16 | Drive write word |
| dev_rdata | input | 16 | Drive read word |

## Verification
A corrupt inbound latch stays hidden until the host reads the high-byte offset. It then shows as a wrong byte two clocks after that read strobe. A corrupt outbound latch shows only in bits 15:8 of the next data-register write, on the clock after that host write. A decode error shows on the clock after the host strobe: wrong chip select, wrong address, or a drive strobe where none is due. The bench therefore reads each latch after each kind of access that could disturb it. It also sweeps every offset in both maps, while a drive-side monitor flags any strobe that was not expected.

// File: rtl/bib_pkg.sv
package bib_pkg;

    localparam int HOST_W = 8;
    localparam int DEV_W  = 16;
    localparam int OFS_W  = 4;
    localparam int REG_W  = 3;
    localparam int PAD_W  = DEV_W - HOST_W;

    localparam logic [OFS_W-1:0] OFS_HIGH = OFS_W'(8);
    localparam logic [OFS_W-1:0] OFS_CTL  = OFS_W'(14);
    localparam logic [OFS_W-1:0] CMD_SPAN = OFS_W'(8);
    localparam logic [REG_W-1:0] CTL_REG  = REG_W'(6);

    typedef enum logic [2:0] {
        K_NONE,
        K_DATA,
        K_CMD,
        K_CTL,
        K_HIGH
    } kind_e;

    typedef struct packed {
        kind_e             kind;
        logic [REG_W-1:0]  rsel;
    } target_t;

    typedef struct packed {
        logic              acc;
        logic              is_rd;
        logic              rd_done;
        kind_e             kind;
        logic [REG_W-1:0]  rsel;
        logic [DEV_W-1:0]  wdata;
    } dev_op_t;

    // Alternate map equals the default map applied to the offset with its end bits exchanged.
    function automatic logic [OFS_W-1:0] swap_ends(input logic [OFS_W-1:0] ofs);
        return {ofs[0], ofs[OFS_W-2:1], ofs[OFS_W-1]};
    endfunction

    function automatic target_t map_offset(input logic [OFS_W-1:0] ofs);
        target_t t;
        t.kind = K_NONE;
        t.rsel = '0;
        if (ofs == '0) begin
            t.kind = K_DATA;
        end else if (ofs < CMD_SPAN) begin
            t.kind = K_CMD;
            t.rsel = ofs[REG_W-1:0];
        end else if (ofs == OFS_HIGH) begin
            t.kind = K_HIGH;
        end else if (ofs == OFS_CTL) begin
            t.kind = K_CTL;
            t.rsel = CTL_REG;
        end
        return t;
    endfunction

    function automatic logic reaches_dev(input kind_e k);
        return (k == K_DATA) || (k == K_CMD) || (k == K_CTL);
    endfunction

endpackage

// File: rtl/bib_decode.sv
module bib_decode
    import bib_pkg::*;
#(
    parameter bit ALT_MAP = 1'b0
) (
    input  logic [OFS_W-1:0] ofs,
    output target_t          tgt
);

    logic [OFS_W-1:0] eff_ofs;

    generate
        if (ALT_MAP) begin : g_alt
            assign eff_ofs = swap_ends(ofs);
        end else begin : g_dflt
            assign eff_ofs = ofs;
        end
    endgenerate

    assign tgt = map_offset(eff_ofs);

endmodule

// File: rtl/bib_hold_reg.sv
module bib_hold_reg #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         ld,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else if (ld) begin
            q <= d;
        end
    end

endmodule

// File: rtl/bib_drive_stage.sv
module bib_drive_stage
    import bib_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              host_rd,
    input  logic              host_wr,
    input  target_t           tgt,
    input  logic [HOST_W-1:0] host_wdata,
    input  logic [HOST_W-1:0] hi_out,
    output dev_op_t           op,
    output logic              dev_cs_cmd,
    output logic              dev_cs_ctl,
    output logic [REG_W-1:0]  dev_addr,
    output logic              dev_rd,
    output logic              dev_wr,
    output logic [DEV_W-1:0]  dev_wdata
);

    dev_op_t op_d;
    logic    wr_go;
    logic    is_dev;

    always_comb begin
        wr_go         = host_wr && !host_rd;
        is_dev        = reaches_dev(tgt.kind);
        op_d          = '0;
        op_d.acc      = (host_rd || wr_go) && is_dev;
        op_d.is_rd    = host_rd;
        op_d.rd_done  = host_rd;
        op_d.kind     = tgt.kind;
        op_d.rsel     = is_dev ? tgt.rsel : '0;
        if (wr_go && is_dev) begin
            op_d.wdata = {(tgt.kind == K_DATA) ? hi_out : {PAD_W{1'b0}}, host_wdata};
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            op <= '0;
        end else begin
            op <= op_d;
        end
    end

    assign dev_cs_cmd = op.acc && ((op.kind == K_DATA) || (op.kind == K_CMD));
    assign dev_cs_ctl = op.acc && (op.kind == K_CTL);
    assign dev_rd     = op.acc && op.is_rd;
    assign dev_wr     = op.acc && !op.is_rd;
    assign dev_addr   = op.acc ? op.rsel : '0;
    assign dev_wdata  = op.wdata;

    // R11
    one_select_chk: assert property (@(posedge clk) disable iff (rst)
        (dev_rd || dev_wr) |-> ($onehot({dev_cs_cmd, dev_cs_ctl}) && $onehot({dev_rd, dev_wr})));

    // R11
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !(dev_rd || dev_wr) |-> (!dev_cs_cmd && !dev_cs_ctl && dev_addr == '0 && dev_wdata == '0));

endmodule

// File: rtl/byte_ide_bridge.sv
module byte_ide_bridge
    import bib_pkg::*;
#(
    parameter bit ALT_MAP = 1'b0
) (
    input  logic        clk,
    input  logic        rst,
    input  logic [3:0]  host_ofs,
    input  logic        host_rd,
    input  logic        host_wr,
    input  logic [7:0]  host_wdata,
    output logic [7:0]  host_rdata,
    output logic        dev_cs_cmd,
    output logic        dev_cs_ctl,
    output logic [2:0]  dev_addr,
    output logic        dev_rd,
    output logic        dev_wr,
    output logic [15:0] dev_wdata,
    input  logic [15:0] dev_rdata
);

    target_t           tgt;
    dev_op_t           op;
    logic [HOST_W-1:0] hi_in_q;
    logic [HOST_W-1:0] hi_out_q;
    logic              ld_out;
    logic              ld_in;

    bib_decode #(.ALT_MAP(ALT_MAP)) u_decode (
        .ofs (host_ofs),
        .tgt (tgt)
    );

    assign ld_out = host_wr && !host_rd && (tgt.kind == K_HIGH);
    assign ld_in  = op.acc && op.is_rd && (op.kind == K_DATA);

    bib_hold_reg #(.W(HOST_W)) u_hi_out (
        .clk (clk),
        .rst (rst),
        .ld  (ld_out),
        .d   (host_wdata),
        .q   (hi_out_q)
    );

    bib_hold_reg #(.W(HOST_W)) u_hi_in (
        .clk (clk),
        .rst (rst),
        .ld  (ld_in),
        .d   (dev_rdata[DEV_W-1:HOST_W]),
        .q   (hi_in_q)
    );

    bib_drive_stage u_drive (
        .clk        (clk),
        .rst        (rst),
        .host_rd    (host_rd),
        .host_wr    (host_wr),
        .tgt        (tgt),
        .host_wdata (host_wdata),
        .hi_out     (hi_out_q),
        .op         (op),
        .dev_cs_cmd (dev_cs_cmd),
        .dev_cs_ctl (dev_cs_ctl),
        .dev_addr   (dev_addr),
        .dev_rd     (dev_rd),
        .dev_wr     (dev_wr),
        .dev_wdata  (dev_wdata)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            host_rdata <= '0;
        end else if (op.rd_done) begin
            case (op.kind)
                K_DATA, K_CMD, K_CTL: host_rdata <= dev_rdata[HOST_W-1:0];
                K_HIGH:               host_rdata <= hi_in_q;
                default:              host_rdata <= '0;
            endcase
        end
    end

    // R11
    drive_follow_chk: assert property (@(posedge clk) disable iff (rst)
        (host_rd && reaches_dev(tgt.kind)) |=> (dev_rd && !dev_wr));

    // R3
    high_wr_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (host_wr && !host_rd && tgt.kind == K_HIGH) |=> !(dev_rd || dev_wr));

    // R8
    unmapped_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        ((host_rd || host_wr) && tgt.kind == K_NONE) |=> !(dev_rd || dev_wr));

    // R1
    latch_capture_chk: assert property (@(posedge clk) disable iff (rst)
        (dev_rd && dev_cs_cmd && dev_addr == '0) |=> (hi_in_q == $past(dev_rdata[DEV_W-1:HOST_W])));

    // R9
    reset_idle_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (host_rdata == '0 && !dev_rd && !dev_wr));

endmodule

// File: tb/test_byte_ide_bridge.sv
module test_byte_ide_bridge;

    localparam int KN = 0;
    localparam int KD = 1;
    localparam int KC = 2;
    localparam int KT = 3;
    localparam int KH = 4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [3:0]  h_ofs = '0;
    logic        h_rd = 1'b0;
    logic        h_wr = 1'b0;
    logic [7:0]  h_wd = '0;
    logic [7:0]  h_rdata;
    logic        d_cmd, d_ctl, d_rd, d_wr;
    logic [2:0]  d_addr;
    logic [15:0] d_wdata, d_rdata;

    logic [3:0]  a_ofs = '0;
    logic        a_rd = 1'b0;
    logic        a_wr = 1'b0;
    logic [7:0]  a_wd = '0;
    logic [7:0]  a_rdata;
    logic        a_cmd, a_ctl, a_drd, a_dwr;
    logic [2:0]  a_addr;
    logic [15:0] a_wdata, a_drdata;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [15:0] mdl [0:8];
    logic [7:0]  in_exp = '0;
    logic [7:0]  out_exp = '0;
    logic [7:0]  a_out_exp = '0;

    logic [7:0]  rd_q [$];
    string       rd_tag_q [$];
    logic [22:0] drv_q [$];
    string       drv_tag_q [$];
    logic        sd1 = 1'b0;
    logic        sd2 = 1'b0;

    always #2 clk = ~clk;

    byte_ide_bridge i_byte_ide_bridge (
        .clk(clk), .rst(rst), .host_ofs(h_ofs), .host_rd(h_rd), .host_wr(h_wr),
        .host_wdata(h_wd), .host_rdata(h_rdata), .dev_cs_cmd(d_cmd), .dev_cs_ctl(d_ctl),
        .dev_addr(d_addr), .dev_rd(d_rd), .dev_wr(d_wr), .dev_wdata(d_wdata), .dev_rdata(d_rdata)
    );

    byte_ide_bridge #(.ALT_MAP(1'b1)) i_byte_ide_bridge_alt (
        .clk(clk), .rst(rst), .host_ofs(a_ofs), .host_rd(a_rd), .host_wr(a_wr),
        .host_wdata(a_wd), .host_rdata(a_rdata), .dev_cs_cmd(a_cmd), .dev_cs_ctl(a_ctl),
        .dev_addr(a_addr), .dev_rd(a_drd), .dev_wr(a_dwr), .dev_wdata(a_wdata), .dev_rdata(a_drdata)
    );

    // Drive models
    assign d_rdata  = d_ctl ? mdl[8] : (d_cmd ? mdl[d_addr] : 16'hFFFF);
    assign a_drdata = {8'h9C, 5'b00110, a_addr};

    always @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < 9; i++) mdl[i] <= 16'h1000 + 16'(i * 16'h0123);
        end else if (d_wr) begin
            mdl[d_ctl ? 4'd8 : {1'b0, d_addr}] <= d_wdata;
        end
    end

    always @(posedge clk) begin
        sd1 <= rst ? 1'b0 : h_rd;
        sd2 <= rst ? 1'b0 : sd1;
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Monitor: drive side and host read side
    always @(negedge clk) begin
        if (!rst) begin
            if (d_rd || d_wr) begin
                if (drv_q.size() == 0) begin
                    check("R8 R3 R2 unexpected drive access", 32'(d_addr), 32'hFFFF_FFFF);
                end else begin
                    logic [22:0] e;
                    string t;
                    e = drv_q.pop_front();
                    t = drv_tag_q.pop_front();
                    check(t, 32'({d_cmd, d_ctl, d_rd, d_wr, d_addr, d_wr ? d_wdata : 16'h0}), 32'(e));
                end
            end
            if (sd2) begin
                if (rd_q.size() == 0) begin
                    check("R11 unexpected read completion", 32'(h_rdata), 32'hFFFF_FFFF);
                end else begin
                    logic [7:0] e;
                    string t;
                    e = rd_q.pop_front();
                    t = rd_tag_q.pop_front();
                    check(t, 32'(h_rdata), 32'(e));
                end
            end
        end
    end

    // Reference maps written from R5..R8
    function automatic void dflt_ref(input logic [3:0] o, output int k, output logic [2:0] a);
        a = 3'd0;
        case (o)
            4'd0: k = KD;
            4'd1, 4'd2, 4'd3, 4'd4, 4'd5, 4'd6, 4'd7: begin k = KC; a = o[2:0]; end
            4'd8: k = KH;
            4'd14: begin k = KT; a = 3'd6; end
            default: k = KN;
        endcase
    endfunction

    function automatic void alt_ref(input logic [3:0] o, output int k, output logic [2:0] a);
        a = 3'd0;
        k = KC;
        case (o)
            4'd0: k = KD;
            4'd1: k = KH;
            4'd2: a = 3'd2;
            4'd4: a = 3'd4;
            4'd6: a = 3'd6;
            4'd7: begin k = KT; a = 3'd6; end
            4'd8: a = 3'd1;
            4'd10: a = 3'd3;
            4'd12: a = 3'd5;
            4'd14: a = 3'd7;
            default: k = KN;
        endcase
    endfunction

    // Driver: pushes expected items, then issues one host access
    task automatic acc(input bit rd, input logic [3:0] o, input logic [7:0] wd, input string tag);
        int k;
        logic [2:0] a;
        logic [7:0] e;
        dflt_ref(o, k, a);
        if (rd) begin
            case (k)
                KD: begin e = mdl[0][7:0]; in_exp = mdl[0][15:8]; end
                KC: e = mdl[a][7:0];
                KT: e = mdl[8][7:0];
                KH: e = in_exp;
                default: e = 8'h00;
            endcase
            rd_q.push_back(e);
            rd_tag_q.push_back({tag, " host read"});
            if (k == KD || k == KC || k == KT) begin
                drv_q.push_back({k != KT, k == KT, 1'b1, 1'b0, a, 16'h0});
                drv_tag_q.push_back({tag, " drive read"});
            end
        end else begin
            case (k)
                KD: begin drv_q.push_back({4'b1001, a, out_exp, wd}); drv_tag_q.push_back({tag, " drive write"}); end
                KC: begin drv_q.push_back({4'b1001, a, 8'h00, wd}); drv_tag_q.push_back({tag, " drive write"}); end
                KT: begin drv_q.push_back({4'b0101, a, 8'h00, wd}); drv_tag_q.push_back({tag, " drive write"}); end
                KH: out_exp = wd;
                default: ;
            endcase
        end
        @(negedge clk);
        h_ofs = o; h_wd = wd; h_rd = rd; h_wr = !rd;
        @(negedge clk);
        h_rd = 1'b0; h_wr = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    // Alternate-map access checked directly at the ports
    task automatic alt_acc(input bit rd, input logic [3:0] o, input logic [7:0] wd, input logic [7:0] rexp);
        int k;
        logic [2:0] a;
        logic [22:0] e;
        alt_ref(o, k, a);
        e = '0;
        if (k == KD || k == KC || k == KT) begin
            e[22:16] = {k != KT, k == KT, rd, !rd, a};
            if (!rd) e[15:0] = {(k == KD) ? a_out_exp : 8'h00, wd};
        end
        if (!rd && k == KH) a_out_exp = wd;
        @(negedge clk);
        a_ofs = o; a_wd = wd; a_rd = rd; a_wr = !rd;
        @(negedge clk);
        a_rd = 1'b0; a_wr = 1'b0;
        check($sformatf("R7 alt map ofs %0d drive side", o),
              32'({a_cmd, a_ctl, a_drd, a_dwr, a_addr, a_dwr ? a_wdata : 16'h0}), 32'(e));
        if (rd) begin
            @(negedge clk);
            check($sformatf("R7 alt map ofs %0d host read", o), 32'(a_rdata), 32'(rexp));
        end
        repeat (2) @(negedge clk);
    endtask

    initial begin
        #(4 * 200000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R9: idle outputs after reset
        check("R9 reset host_rdata", 32'(h_rdata), 32'h0);
        check("R9 reset drive strobes", 32'({d_cmd, d_ctl, d_rd, d_wr}), 32'h0);
        acc(1'b1, 4'd8, 8'h00, "R9 R2 inbound latch after reset");
        acc(1'b0, 4'd0, 8'h3C, "R9 R4 outbound latch after reset");
        acc(1'b0, 4'd8, 8'hA7, "R3 high write");
        acc(1'b0, 4'd0, 8'h11, "R4 data write");
        acc(1'b0, 4'd0, 8'h22, "R10 R4 repeat data write");
        acc(1'b1, 4'd0, 8'h00, "R1 data read");
        acc(1'b1, 4'd8, 8'h00, "R2 high read");
        for (int o = 1; o < 8; o++) acc(1'b1, 4'(o), 8'h00, "R5 command read");
        acc(1'b1, 4'd8, 8'h00, "R10 inbound latch held");
        acc(1'b0, 4'd3, 8'h5E, "R5 command write");
        acc(1'b0, 4'd7, 8'hEC, "R5 command write");
        acc(1'b1, 4'd3, 8'h00, "R5 readback");
        acc(1'b1, 4'd14, 8'h00, "R6 control read");
        acc(1'b0, 4'd14, 8'h02, "R6 control write");
        acc(1'b1, 4'd14, 8'h00, "R6 control readback");
        for (int o = 9; o < 16; o++) begin
            if (o != 14) begin
                acc(1'b1, 4'(o), 8'h00, "R8 unmapped read");
                acc(1'b0, 4'(o), 8'h99, "R8 unmapped write");
            end
        end
        acc(1'b1, 4'd8, 8'h00, "R8 R10 inbound latch after unmapped");
        acc(1'b0, 4'd0, 8'h44, "R8 R10 outbound latch after unmapped");
        acc(1'b1, 4'd0, 8'h00, "R1 data read after write");
        acc(1'b1, 4'd8, 8'h00, "R1 R2 new high byte");
        repeat (4) @(negedge clk);
        check("R11 all drive accesses seen", 32'(drv_q.size()), 32'h0);
        check("R11 all host reads seen", 32'(rd_q.size()), 32'h0);

        // Alternate map: sweep all offsets with writes, then reads of data and high byte
        for (int o = 0; o < 16; o++) alt_acc(1'b0, 4'(o), 8'(8'h40 + o), 8'h00);
        alt_acc(1'b0, 4'd0, 8'h5A, 8'h00);
        alt_acc(1'b1, 4'd0, 8'h00, 8'h30);
        alt_acc(1'b1, 4'd1, 8'h00, 8'h9C);
        alt_acc(1'b1, 4'd7, 8'h00, 8'h36);
        alt_acc(1'b1, 4'd3, 8'h00, 8'h00);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule